// File: doc/BRIEF.md
# Self-Timed Single-Wire Nibble Transmitter

This block drives one output line that stays high while idle and carries a byte to an addressed receiver. The byte is split into two frames, each with ten bit periods. A frame begins with a low pulse one bit period long and a high bit. The receiver measures the low pulse to learn the bit rate. Next come the three target-address bits and four data bits, and the frame ends with a high stop bit. The lower nibble goes out first and the upper nibble second, and both frames carry the same address.

A byte, its target address and a bit-period count are offered on a valid/ready handshake. The period is given in system clocks and is captured when the byte is accepted. A receiver that may have lost frame alignment is brought back in step by a long all-high stretch before the frames. This stretch is always sent on the first transfer after reset. On later transfers it is sent only when the preamble request input is high at acceptance. The busy output covers the whole transmission.

Top module: `onewire_nibble_tx`

## Requirements
- R1: While no transfer is in progress, including during and after reset, `line_out` is high, `busy` is low and `in_ready` is high.
- R2: Each frame is ten bit periods long. Period 0 is low, period 1 is high, periods 2-4 carry the address bits (index 0 first), periods 5-8 carry the nibble (bit 0 first), and period 9 is a high stop bit.
- R3: The first frame carries `in_data[3:0]` and the second frame carries `in_data[7:4]`. Both frames carry the address captured with the byte.
- R4: Each bit lasts the number of clocks on `bit_period` at acceptance. A value below 4 is treated as 4. The opening low pulse of a frame is therefore exactly one period.
- R5: The first transfer after reset is preceded by a high preamble of twenty bit periods, which is two frame lengths.
- R6: Later transfers are preceded by the preamble only when `preamble_req` is high at acceptance. Otherwise the first frame starts in the cycle after acceptance.
- R7: A byte is accepted in a cycle where `in_valid` and `in_ready` are both high. `busy` is then high from the next cycle for exactly (number of bits × period) cycles, and `in_ready` is the inverse of `busy`.
- R8: Activity on `in_valid`, `in_data`, `in_addr` and `bit_period` while `busy` is high has no effect on the line or on the length of the transfer.
- R9: The stop bit between the two frames of a byte lasts exactly one period. A new byte may be accepted in the first cycle after `busy` falls, with no extra idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; arms the preamble |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The block can accept a byte |
| in_data | input | 8 | Byte to send (low nibble first) |
| in_addr | input | 3 | Target address placed in both frames |
| bit_period | input | 8 | Clocks per bit, minimum 4 |
| preamble_req | input | 1 | Send the high preamble before this byte |
| line_out | output | 1 | Serial line, high when idle |
| busy | output | 1 | A transfer is in progress |

## Verification
The block accepts a byte on a clock edge. Bit k of that transfer then appears on `line_out` from the following cycle, starting k × P cycles after the acceptance edge. `busy` rises in that same following cycle and falls N × P cycles later, where N is 20, or 40 when the preamble is sent. At each acceptance the bench builds the expected line level for every one of those cycles. A falling-edge monitor compares one entry per cycle for as long as `busy` is high. The monitor reports an error if `busy` outlasts the expected entries, or if `busy` falls while entries remain. This fixes both the timing of each bit and the end of the transfer to the exact cycle.

// File: rtl/nwtx_pkg.sv
package nwtx_pkg;
   // Transmission phase of the sequencer
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_PRE   = 2'd1,
      PH_FRAME = 2'd2
   } phase_e;

   // Number of bit periods in one frame: start low, start high, address, nibble, stop
   function automatic int frame_bits(input int addr_w, input int nib_w);
      return 3 + addr_w + nib_w;
   endfunction
endpackage

// File: rtl/nwtx_bit_timer.sv
module nwtx_bit_timer #(
   parameter int PER_W   = 8,
   parameter int MIN_PER = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic [PER_W-1:0] period_in,
   output logic             bit_end
);
   localparam logic [PER_W-1:0] MIN_V = PER_W'(MIN_PER);
   localparam logic [PER_W-1:0] ONE_V = PER_W'(1);

   logic [PER_W-1:0] per_q;
   logic [PER_W-1:0] cnt_q;

   assign bit_end = run && (cnt_q == per_q - ONE_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q <= MIN_V;
         cnt_q <= '0;
      end else if (start) begin
         per_q <= (period_in < MIN_V) ? MIN_V : period_in;
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= bit_end ? '0 : cnt_q + ONE_V;
      end
   end
endmodule

// File: rtl/nwtx_frame_builder.sv
module nwtx_frame_builder #(
   parameter int ADDR_W = 3,
   parameter int NIB_W  = 4,
   parameter int FR_W   = 3 + ADDR_W + NIB_W
) (
   input  logic [2*NIB_W-1:0] data,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               upper,
   output logic [FR_W-1:0]    frame
);
   logic [NIB_W-1:0] nib;

   assign nib = upper ? data[2*NIB_W-1:NIB_W] : data[NIB_W-1:0];

   // Timing edge of the frame: low then high
   assign frame[0] = 1'b0;
   assign frame[1] = 1'b1;

   for (genvar g = 0; g < ADDR_W; g++) begin : g_addr
      assign frame[2+g] = addr[g];
   end

   for (genvar g = 0; g < NIB_W; g++) begin : g_nib
      assign frame[2+ADDR_W+g] = nib[g];
   end

   assign frame[FR_W-1] = 1'b1;
endmodule

// File: rtl/nwtx_sequencer.sv
module nwtx_sequencer
   import nwtx_pkg::*;
#(
   parameter int FR_BITS  = 10,
   parameter int PRE_BITS = 20,
   parameter int IDX_W    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             want_pre,
   input  logic             bit_end,
   output phase_e           phase,
   output logic             upper,
   output logic [IDX_W-1:0] bit_idx
);
   localparam logic [IDX_W-1:0] FR_LAST  = IDX_W'(FR_BITS - 1);
   localparam logic [IDX_W-1:0] PRE_LAST = IDX_W'((PRE_BITS > 0) ? PRE_BITS - 1 : 0);
   localparam bit               PRE_ON   = (PRE_BITS > 0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         upper   <= 1'b0;
         bit_idx <= '0;
      end else if (start) begin
         phase   <= (PRE_ON && want_pre) ? PH_PRE : PH_FRAME;
         upper   <= 1'b0;
         bit_idx <= '0;
      end else if (bit_end) begin
         unique case (phase)
            PH_PRE: begin
               if (bit_idx == PRE_LAST) begin
                  phase   <= PH_FRAME;
                  bit_idx <= '0;
               end else begin
                  bit_idx <= bit_idx + 1'b1;
               end
            end
            PH_FRAME: begin
               if (bit_idx == FR_LAST) begin
                  bit_idx <= '0;
                  if (upper) begin
                     phase <= PH_IDLE;
                     upper <= 1'b0;
                  end else begin
                     upper <= 1'b1;
                  end
               end else begin
                  bit_idx <= bit_idx + 1'b1;
               end
            end
            default: begin
               phase   <= PH_IDLE;
               bit_idx <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/onewire_nibble_tx.sv
module onewire_nibble_tx
   import nwtx_pkg::*;
#(
   parameter int ADDR_W     = 3,
   parameter int NIB_W      = 4,
   parameter int PER_W      = 8,
   parameter int MIN_PER    = 4,
   parameter int PRE_FRAMES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [2*NIB_W-1:0]  in_data,
   input  logic [ADDR_W-1:0]   in_addr,
   input  logic [PER_W-1:0]    bit_period,
   input  logic                preamble_req,
   output logic                line_out,
   output logic                busy
);
   localparam int FR_BITS  = frame_bits(ADDR_W, NIB_W);
   localparam int PRE_BITS = PRE_FRAMES * FR_BITS;
   localparam int CNT_MAX  = (PRE_BITS > FR_BITS) ? PRE_BITS : FR_BITS;
   localparam int IDX_W    = $clog2(CNT_MAX);
   localparam int FIDX_W   = $clog2(FR_BITS);

   // Elaboration-time parameter checks
   if (MIN_PER < 4) begin : g_bad_min
      $error("MIN_PER must be at least 4");
   end
   if (MIN_PER >= (1 << PER_W)) begin : g_bad_per_w
      $error("PER_W too narrow for MIN_PER");
   end
   if (ADDR_W < 1 || NIB_W < 1) begin : g_bad_fields
      $error("ADDR_W and NIB_W must be positive");
   end
   if (PRE_FRAMES < 0) begin : g_bad_pre
      $error("PRE_FRAMES must not be negative");
   end

   phase_e              phase;
   logic                upper;
   logic [IDX_W-1:0]    bit_idx;
   logic                bit_end;
   logic                accept;
   logic                armed;
   logic [2*NIB_W-1:0]  data_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [FR_BITS-1:0]  frame_vec;

   assign busy     = (phase != PH_IDLE);
   assign in_ready = !busy;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         addr_q <= '0;
      end else if (accept) begin
         data_q <= in_data;
         addr_q <= in_addr;
      end
   end

   // Preamble arming: set by reset, consumed by the next accepted byte
   if (PRE_FRAMES > 0) begin : g_arm
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      armed <= 1'b1;
         else if (accept) armed <= 1'b0;
      end
   end else begin : g_no_arm
      assign armed = 1'b0;
   end

   nwtx_bit_timer #(
      .PER_W   (PER_W),
      .MIN_PER (MIN_PER)
   ) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .run       (busy),
      .period_in (bit_period),
      .bit_end   (bit_end)
   );

   nwtx_sequencer #(
      .FR_BITS  (FR_BITS),
      .PRE_BITS (PRE_BITS),
      .IDX_W    (IDX_W)
   ) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .want_pre (armed || preamble_req),
      .bit_end  (bit_end),
      .phase    (phase),
      .upper    (upper),
      .bit_idx  (bit_idx)
   );

   nwtx_frame_builder #(
      .ADDR_W (ADDR_W),
      .NIB_W  (NIB_W),
      .FR_W   (FR_BITS)
   ) i_build (
      .data  (data_q),
      .addr  (addr_q),
      .upper (upper),
      .frame (frame_vec)
   );

   always_comb begin
      unique case (phase)
         PH_FRAME: line_out = frame_vec[bit_idx[FIDX_W-1:0]];
         default:  line_out = 1'b1;
      endcase
   end
endmodule

// File: rtl/nwtx_checker.sv
module nwtx_checker #(
   parameter int MIN_PER = 4,
   parameter bit PRE_ON  = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic busy,
   input logic line_out
);
   logic        lvl_q;
   logic [15:0] run_q;
   logic        first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q   <= 1'b1;
         run_q   <= 16'd1;
         first_q <= 1'b1;
      end else begin
         if (line_out != lvl_q) begin
            lvl_q <= line_out;
            run_q <= 16'd1;
         end else if (run_q != 16'hFFFF) begin
            run_q <= run_q + 16'd1;
         end
         if (busy) first_q <= 1'b0;
      end
   end

   // R1: the line is high whenever nothing is being sent
   a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> line_out);

   // R7: an accepted byte makes the block busy in the next cycle
   a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> busy);

   // R4: no level on the line is shorter than the minimum bit period
   a_r4_min_run: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && line_out != lvl_q) |-> (run_q >= 16'(MIN_PER)));

   // R5: the first transfer after reset opens with the high preamble
   a_r5_first_high: assert property (@(posedge clk) disable iff (!rst_n)
      (PRE_ON && first_q && $rose(busy)) |-> line_out);

   // R2: a transfer ends on a high stop bit
   a_r2_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(line_out));
endmodule

bind onewire_nibble_tx nwtx_checker #(
   .MIN_PER (MIN_PER),
   .PRE_ON  (PRE_FRAMES > 0)
) i_nwtx_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .busy     (busy),
   .line_out (line_out)
);

// File: tb/test_onewire_nibble_tx.sv
module test_onewire_nibble_tx;
   localparam int MINP = 4;
   localparam int FB   = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_data = '0;
   logic [2:0] in_addr = '0;
   logic [7:0] bit_period = 8'd4;
   logic       preamble_req = 1'b0;
   logic       line_out;
   logic       busy;

   bit    q_lvl[$];
   string q_req[$];
   int    n_tests = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   bit    prev_busy = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   onewire_nibble_tx i_onewire_nibble_tx (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_ready     (in_ready),
      .in_data      (in_data),
      .in_addr      (in_addr),
      .bit_period   (bit_period),
      .preamble_req (preamble_req),
      .line_out     (line_out),
      .busy         (busy)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic push_bit(input int p, input bit lvl, input string req);
      for (int i = 0; i < p; i++) begin
         q_lvl.push_back(lvl);
         q_req.push_back(req);
      end
   endtask

   // Driver: offers one byte and fills the scoreboard at acceptance
   task automatic send(input logic [7:0] d, input logic [2:0] a, input int per,
                       input bit req_pre, input bit exp_pre, input string pre_tag);
      int pe;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid     = 1'b1;
      in_data      = d;
      in_addr      = a;
      bit_period   = 8'(per);
      preamble_req = req_pre;
      @(posedge clk);
      #1;
      pe = (per < MINP) ? MINP : per;
      if (exp_pre) push_bit(2 * FB * pe, 1'b1, pre_tag);
      for (int f = 0; f < 2; f++) begin
         logic [3:0] nib;
         nib = (f == 0) ? d[3:0] : d[7:4];
         push_bit(pe, 1'b0, "R4");                       // timing low
         push_bit(pe, 1'b1, "R2");
         for (int k = 0; k < 3; k++) push_bit(pe, a[k], "R3");
         for (int k = 0; k < 4; k++) push_bit(pe, nib[k], (f == 0) ? "R2" : "R3");
         push_bit(pe, 1'b1, (f == 0) ? "R9" : "R2");     // stop bit
      end
      @(negedge clk);
      in_valid     = 1'b0;
      preamble_req = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (q_lvl.size() == 0 && !busy) return;
      end
      chk(1'b0, "R7", "transfer did not complete", q_lvl.size(), 0);
      q_lvl.delete();
      q_req.delete();
   endtask

   // Monitor: compares the line against the scoreboard once per cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(in_ready == !busy, "R7", "ready vs busy", in_ready, !busy);
         if (busy) begin
            if (q_lvl.size() == 0) begin
               chk(1'b0, "R7", "busy beyond final stop", busy, 0);
            end else begin
               bit    e;
               string r;
               e = q_lvl.pop_front();
               r = q_req.pop_front();
               chk(line_out == e, r, "line level", line_out, e);
            end
         end else begin
            chk(line_out == 1'b1, "R1", "idle line", line_out, 1);
            if (prev_busy && q_lvl.size() != 0) begin
               chk(1'b0, "R7", "busy ended early, cycles left", q_lvl.size(), 0);
               q_lvl.delete();
               q_req.delete();
            end
         end
         prev_busy = busy;
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL R7 watchdog expired: actual=%0d expected=%0d", 0, 1);
      finish_run();
   end

   initial begin
      // R1: state during and after reset
      repeat (3) @(negedge clk);
      chk(line_out == 1'b1, "R1", "line in reset", line_out, 1);
      chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
      chk(in_ready == 1'b1, "R1", "ready in reset", in_ready, 1);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R5: first byte after reset gets the preamble without a request
      send(8'hA5, 3'd3, 5, 1'b0, 1'b1, "R5");
      wait_idle();

      // R6: no request, no preamble
      send(8'h3C, 3'd6, 4, 1'b0, 1'b0, "R6");
      wait_idle();

      // R6: requested preamble
      send(8'h81, 3'd1, 6, 1'b1, 1'b1, "R6");
      wait_idle();

      // R9: back-to-back bytes with different periods
      send(8'hF0, 3'd7, 4, 1'b0, 1'b0, "R6");
      send(8'h0F, 3'd0, 7, 1'b0, 1'b0, "R6");
      wait_idle();

      // R4: periods below the minimum are raised to it
      send(8'h96, 3'd5, 2, 1'b0, 1'b0, "R6");
      wait_idle();
      send(8'h69, 3'd2, 0, 1'b0, 1'b0, "R6");
      wait_idle();

      // R8: offers made while busy are ignored
      send(8'h5A, 3'd4, 5, 1'b0, 1'b0, "R6");
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         in_valid   = 1'b1;
         in_data    = 8'hFF;
         in_addr    = 3'd7;
         bit_period = 8'd9;
      end
      @(negedge clk);
      in_valid = 1'b0;
      chk(busy == 1'b1, "R8", "still busy after ignored offers", busy, 1);
      wait_idle();
      repeat (20) @(negedge clk);
      chk(busy == 1'b0, "R8", "no extra transfer", busy, 0);

      // R5: reset re-arms the preamble
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(line_out == 1'b1, "R1", "line in second reset", line_out, 1);
      rst_n = 1'b1;
      @(negedge clk);
      send(8'hC3, 3'd6, 4, 1'b0, 1'b1, "R5");
      wait_idle();
      repeat (5) @(negedge clk);
      chk(q_lvl.size() == 0, "R7", "scoreboard drained", q_lvl.size(), 0);
      finish_run();
   end
endmodule